// File: doc/BRIEF.md
# Two-Level Page Table Walker

The walker turns a 32-bit linear address into a physical address. It reads a directory entry located from a root frame number and then a table entry located from that directory entry. Along the way it checks the requested access against the rights held in both entries and applies the write-protect control. The result is a physical address or a page fault. The fault carries the faulting linear address and a 3-bit error code.

Requests arrive one at a time on a valid/ready pair. Each request gets exactly one single-cycle response. Entries are fetched and updated through a 32-bit memory port. That port holds its request until the memory acknowledges it, and read data is taken in the acknowledge cycle.

When the accessed flag is clear, the walker sets it in each entry it uses. When a write hits a table entry whose dirty flag is clear, the walker sets the dirty flag. In both cases the updated entry is written back before the walk completes.

The rights decision is one lookup in a 32-entry table. The table is indexed by these bits:
- the write request;
- the AND of the two writable bits;
- the AND of the two user bits;
- the current mode;
- the write-protect control.

The fault error code is built from the same bits.

Top module: `pt_walker`

## Requirements
- R1: After reset, req_ready_o is 1, rsp_valid_o is 0, mem_req_o is 0, and fault_addr_o and fault_code_o are 0.
- R2: The directory entry is read at {root_frame_i, 12'h000} + 4*linear[31:22]. The table entry is read at {directory entry[31:12], 12'h000} + 4*linear[21:12]. A successful response gives rsp_paddr_o = {table entry[31:12], linear[11:0]}. Entry bits are: present = bit 0, writable = bit 1, user = bit 2, accessed = bit 5, dirty = bit 6.
- R3: Rights use W = directory writable AND table writable, and U = directory user AND table user. A supervisor read is always allowed. A supervisor write is allowed when W is 1 or wp_i is 0. A user access needs U = 1. A user write also needs W = 1, whatever the value of wp_i.
- R4: On an allowed write to a table entry whose dirty bit is clear, the entry is written back with the dirty bit set before the response. A read never sets the dirty bit.
- R5: An entry whose accessed bit is clear is written back with the accessed bit set. This applies to the directory entry before the table entry is read, and to the table entry before the response. When no flag changes, the walk issues no memory write.
- R6: A directory entry with present = 0 faults with error code bit 0 = 0, after exactly one memory read and no write.
- R7: A table entry with present = 0 faults with error code bit 0 = 0.
- R8: A rights violation faults with error code bit 0 = 1, and the table entry is not written.
- R9: On a fault, fault_addr_o takes the linear address. fault_code_o takes {user mode, write, protection} in bits 2, 1, 0. Both values are visible while the fault response is valid and hold until the next fault, so a successful walk leaves them unchanged.
- R10: A request is accepted only while req_ready_o is 1, which is only when no walk is in progress. Each request gives exactly one rsp_valid_o pulse of one cycle. rsp_fault_o is 1 on a fault response and 0 on a successful one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| root_frame_i | input | 20 | Frame number of the page directory |
| wp_i | input | 1 | Write-protect control for supervisor writes |
| req_valid_i | input | 1 | Translation request |
| req_ready_o | output | 1 | Walker idle, request accepted |
| req_addr_i | input | 32 | Linear address |
| req_write_i | input | 1 | Access is a write |
| req_user_i | input | 1 | Access is from user mode |
| rsp_valid_o | output | 1 | One-cycle response pulse |
| rsp_fault_o | output | 1 | Response is a page fault |
| rsp_paddr_o | output | 32 | Physical address of a successful walk |
| fault_addr_o | output | 32 | Latched faulting linear address |
| fault_code_o | output | 3 | Latched fault error code |
| mem_req_o | output | 1 | Memory access request, held until acknowledged |
| mem_we_o | output | 1 | Memory access is a write |
| mem_addr_o | output | 32 | Byte address of the entry |
| mem_wdata_o | output | 32 | Entry value to write |
| mem_ack_i | input | 1 | Memory acknowledge |
| mem_rdata_i | input | 32 | Read data, valid with the acknowledge |

## Verification
Each flag state is walked in turn, and the physical address and the count of memory reads and writes are compared on every walk:
- Entries with accessed clear, then set, separate the flag-update path from the no-write path.
- Writes to a clean page, then to a dirty page, separate the dirty update from a plain walk.

The rights table is exercised over user and supervisor, read and write, and both wp_i values, against a directory entry that grants user but not writable rights. This shows that the AND of the two levels, rather than either entry alone, decides the outcome. Not-present entries at each level separate the two fault points by the number of reads and by error code bit 0. A successful walk after a fault shows that the fault address and code are held.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;
  localparam int P_BIT = 0;
  localparam int W_BIT = 1;
  localparam int U_BIT = 2;
  localparam int A_BIT = 5;
  localparam int D_BIT = 6;
  localparam int IDX_W = 5;

  typedef enum logic [2:0] {
    S_IDLE, S_PDE_RD, S_PDE_WB, S_PTE_RD, S_PTE_WB, S_DONE, S_FAULT
  } walk_st_e;

  // idx: [0]=write [1]=W both [2]=U both [3]=user mode [4]=write protect
  function automatic logic rights_ok(input logic [IDX_W-1:0] idx);
    if (idx[3]) return idx[2] && (!idx[0] || idx[1]);
    return !idx[0] || idx[1] || !idx[4];
  endfunction
endpackage

// File: rtl/pt_rights_lut.sv
module pt_rights_lut
  import pt_walk_pkg::*;
(
  input  logic [IDX_W-1:0] idx_i,
  output logic             allowed_o
);
  localparam int N = 1 << IDX_W;
  logic [N-1:0] tab;

  for (genvar g = 0; g < N; g++) begin : g_tab
    assign tab[g] = rights_ok(IDX_W'(g));
  end

  assign allowed_o = tab[idx_i];
endmodule

// File: rtl/pt_fault_latch.sv
module pt_fault_latch #(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          evt_i,
  input  logic [AW-1:0] addr_i,
  input  logic [2:0]    code_i,
  output logic [AW-1:0] fault_addr_o,
  output logic [2:0]    fault_code_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fault_addr_o <= '0;
      fault_code_o <= '0;
    end else if (evt_i) begin
      fault_addr_o <= addr_i;
      fault_code_o <= code_i;
    end
  end

  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evt_i |=> ($stable(fault_addr_o) && $stable(fault_code_o)));
  a_r9_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i |=> (fault_addr_o == $past(addr_i)));
endmodule

// File: rtl/pt_walk_fsm.sv
module pt_walk_fsm
  import pt_walk_pkg::*;
#(
  parameter int DIR_W = 10,
  parameter int TBL_W = 10,
  parameter int OFF_W = 12
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [DIR_W+TBL_W-1:0]    root_frame_i,
  input  logic                      wp_i,
  input  logic                      req_valid_i,
  output logic                      req_ready_o,
  input  logic [DIR_W+TBL_W+OFF_W-1:0] req_addr_i,
  input  logic                      req_write_i,
  input  logic                      req_user_i,
  output logic                      rsp_valid_o,
  output logic                      rsp_fault_o,
  output logic [DIR_W+TBL_W+OFF_W-1:0] rsp_paddr_o,
  output logic                      fault_evt_o,
  output logic [2:0]                fault_code_o,
  output logic [DIR_W+TBL_W+OFF_W-1:0] cur_addr_o,
  output logic                      cur_write_o,
  output logic                      cur_user_o,
  output logic [IDX_W-1:0]          rights_idx_o,
  input  logic                      rights_ok_i,
  output logic                      mem_req_o,
  output logic                      mem_we_o,
  output logic [DIR_W+TBL_W+OFF_W-1:0] mem_addr_o,
  output logic [DIR_W+TBL_W+OFF_W-1:0] mem_wdata_o,
  input  logic                      mem_ack_i,
  input  logic [DIR_W+TBL_W+OFF_W-1:0] mem_rdata_i
);
  localparam int AW = DIR_W + TBL_W + OFF_W;
  localparam logic [AW-1:0] A_MASK = AW'(1) << A_BIT;
  localparam logic [AW-1:0] D_MASK = AW'(1) << D_BIT;

  walk_st_e      st_q, st_d;
  logic [AW-1:0] addr_q, pde_q, pte_q;
  logic          wr_q, usr_q;
  logic          prot;
  logic [AW-1:0] pde_addr, pte_addr;
  logic          need_wb;

  assign pde_addr = {root_frame_i, OFF_W'(0)} + AW'({addr_q[AW-1 -: DIR_W], 2'b00});
  assign pte_addr = {pde_q[AW-1:OFF_W], OFF_W'(0)} + AW'({addr_q[OFF_W +: TBL_W], 2'b00});
  assign need_wb  = !mem_rdata_i[A_BIT] || (wr_q && !mem_rdata_i[D_BIT]);

  assign rights_idx_o = {wp_i, usr_q,
                         pde_q[U_BIT] & mem_rdata_i[U_BIT],
                         pde_q[W_BIT] & mem_rdata_i[W_BIT],
                         wr_q};

  always_comb begin
    st_d        = st_q;
    fault_evt_o = 1'b0;
    prot        = 1'b0;
    unique case (st_q)
      S_IDLE:   if (req_valid_i) st_d = S_PDE_RD;
      S_PDE_RD: if (mem_ack_i) begin
        if (!mem_rdata_i[P_BIT]) begin
          st_d = S_FAULT; fault_evt_o = 1'b1;
        end else if (!mem_rdata_i[A_BIT]) st_d = S_PDE_WB;
        else st_d = S_PTE_RD;
      end
      S_PDE_WB: if (mem_ack_i) st_d = S_PTE_RD;
      S_PTE_RD: if (mem_ack_i) begin
        if (!mem_rdata_i[P_BIT]) begin
          st_d = S_FAULT; fault_evt_o = 1'b1;
        end else if (!rights_ok_i) begin
          st_d = S_FAULT; fault_evt_o = 1'b1; prot = 1'b1;
        end else if (need_wb) st_d = S_PTE_WB;
        else st_d = S_DONE;
      end
      S_PTE_WB: if (mem_ack_i) st_d = S_DONE;
      default:  st_d = S_IDLE;
    endcase
  end

  assign fault_code_o = {usr_q, wr_q, prot};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      addr_q <= '0;
      wr_q   <= 1'b0;
      usr_q  <= 1'b0;
      pde_q  <= '0;
      pte_q  <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == S_IDLE && req_valid_i) begin
        addr_q <= req_addr_i;
        wr_q   <= req_write_i;
        usr_q  <= req_user_i;
      end
      if (st_q == S_PDE_RD && mem_ack_i) pde_q <= mem_rdata_i | A_MASK;
      if (st_q == S_PTE_RD && mem_ack_i)
        pte_q <= mem_rdata_i | A_MASK | (wr_q ? D_MASK : '0);
    end
  end

  assign req_ready_o = (st_q == S_IDLE);
  assign rsp_valid_o = (st_q == S_DONE) || (st_q == S_FAULT);
  assign rsp_fault_o = (st_q == S_FAULT);
  assign rsp_paddr_o = (st_q == S_DONE) ? {pte_q[AW-1:OFF_W], addr_q[OFF_W-1:0]} : '0;
  assign mem_req_o   = (st_q == S_PDE_RD) || (st_q == S_PDE_WB) ||
                       (st_q == S_PTE_RD) || (st_q == S_PTE_WB);
  assign mem_we_o    = (st_q == S_PDE_WB) || (st_q == S_PTE_WB);
  assign mem_addr_o  = (st_q == S_PDE_RD || st_q == S_PDE_WB) ? pde_addr : pte_addr;
  assign mem_wdata_o = (st_q == S_PDE_WB) ? pde_q : pte_q;
  assign cur_addr_o  = addr_q;
  assign cur_write_o = wr_q;
  assign cur_user_o  = usr_q;

  a_r10_one_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
  a_r10_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !req_ready_o);
  a_r6_pde_np: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_PDE_RD && mem_ack_i && !mem_rdata_i[P_BIT]) |=> (rsp_fault_o && !mem_req_o));
  a_r4_dirty_wb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_PTE_WB && wr_q) |-> mem_wdata_o[D_BIT]);
  a_r8_no_wb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_evt_o && prot) |=> !mem_we_o);
  a_r2_mem_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> ($stable(mem_addr_o) && mem_req_o));
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walk_pkg::*;
#(
  parameter int DIR_W = 10,
  parameter int TBL_W = 10,
  parameter int OFF_W = 12
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [DIR_W+TBL_W-1:0]       root_frame_i,
  input  logic                         wp_i,
  input  logic                         req_valid_i,
  output logic                         req_ready_o,
  input  logic [DIR_W+TBL_W+OFF_W-1:0] req_addr_i,
  input  logic                         req_write_i,
  input  logic                         req_user_i,
  output logic                         rsp_valid_o,
  output logic                         rsp_fault_o,
  output logic [DIR_W+TBL_W+OFF_W-1:0] rsp_paddr_o,
  output logic [DIR_W+TBL_W+OFF_W-1:0] fault_addr_o,
  output logic [2:0]                   fault_code_o,
  output logic                         mem_req_o,
  output logic                         mem_we_o,
  output logic [DIR_W+TBL_W+OFF_W-1:0] mem_addr_o,
  output logic [DIR_W+TBL_W+OFF_W-1:0] mem_wdata_o,
  input  logic                         mem_ack_i,
  input  logic [DIR_W+TBL_W+OFF_W-1:0] mem_rdata_i
);
  localparam int AW = DIR_W + TBL_W + OFF_W;

  logic             fault_evt, rights_ok_w, cur_wr, cur_usr;
  logic [2:0]       code_next;
  logic [AW-1:0]    cur_addr;
  logic [IDX_W-1:0] rights_idx;

  pt_walk_fsm #(.DIR_W(DIR_W), .TBL_W(TBL_W), .OFF_W(OFF_W)) u_fsm (
    .clk_i, .rst_ni, .root_frame_i, .wp_i,
    .req_valid_i, .req_ready_o, .req_addr_i, .req_write_i, .req_user_i,
    .rsp_valid_o, .rsp_fault_o, .rsp_paddr_o,
    .fault_evt_o(fault_evt), .fault_code_o(code_next),
    .cur_addr_o(cur_addr), .cur_write_o(cur_wr), .cur_user_o(cur_usr),
    .rights_idx_o(rights_idx), .rights_ok_i(rights_ok_w),
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_ack_i, .mem_rdata_i
  );

  pt_rights_lut u_lut (.idx_i(rights_idx), .allowed_o(rights_ok_w));

  pt_fault_latch #(.AW(AW)) u_flt (
    .clk_i, .rst_ni, .evt_i(fault_evt), .addr_i(cur_addr), .code_i(code_next),
    .fault_addr_o, .fault_code_o
  );

  a_r3_user_needs_u: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rights_idx[3] && !rights_idx[2]) |-> !rights_ok_w);
  a_r3_sup_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rights_idx[3] && !rights_idx[0]) |-> rights_ok_w);
  a_r9_fault_regs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fault_o) |->
      (fault_addr_o == cur_addr && fault_code_o[2] == cur_usr && fault_code_o[1] == cur_wr));
endmodule

// File: tb/pt_walker_test.sv
`timescale 1ns/1ps
module pt_walker_test;
  logic        clk = 0, rst_n = 0;
  logic [19:0] root_frame = 20'h00001;
  logic        wp = 1;
  logic        req_valid = 0, req_write = 0, req_user = 0;
  logic [31:0] req_addr = '0;
  logic        req_ready, rsp_valid, rsp_fault;
  logic [31:0] rsp_paddr, fault_addr;
  logic [2:0]  fault_code;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack = 0;
  logic [31:0] mem_rdata = '0;

  logic [31:0] mem [0:16383];
  int          rd_cnt = 0, wr_cnt = 0;
  logic        poke_en = 0;
  logic [31:0] poke_addr = '0, poke_data = '0;

  int total = 0, bad = 0;
  logic        got_fault;
  logic [31:0] got_paddr;
  int          d_rd, d_wr;

  always #2.5 clk = ~clk;

  pt_walker uut (
    .clk_i(clk), .rst_ni(rst_n), .root_frame_i(root_frame), .wp_i(wp),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_addr_i(req_addr),
    .req_write_i(req_write), .req_user_i(req_user),
    .rsp_valid_o(rsp_valid), .rsp_fault_o(rsp_fault), .rsp_paddr_o(rsp_paddr),
    .fault_addr_o(fault_addr), .fault_code_o(fault_code),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata)
  );

  initial for (int i = 0; i < 16384; i++) mem[i] = '0;

  always @(posedge clk) begin
    if (poke_en) mem[poke_addr[15:2]] <= poke_data;
    if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) begin
        mem[mem_addr[15:2]] <= mem_wdata;
        wr_cnt <= wr_cnt + 1;
      end else begin
        mem_rdata <= mem[mem_addr[15:2]];
        rd_cnt <= rd_cnt + 1;
      end
    end else mem_ack <= 1'b0;
  end

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  task automatic poke(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk); poke_en = 1; poke_addr = a; poke_data = d;
    @(negedge clk); poke_en = 0;
  endtask

  task automatic walk(input logic [31:0] la, input logic w, input logic u);
    int rd0, wr0;
    @(negedge clk);
    rd0 = rd_cnt; wr0 = wr_cnt;
    req_valid = 1; req_addr = la; req_write = w; req_user = u;
    @(negedge clk);
    req_valid = 0;
    chk("R10 busy ready", 32'(req_ready), 0);
    while (!rsp_valid) @(negedge clk);
    got_fault = rsp_fault; got_paddr = rsp_paddr;
    @(negedge clk);
    chk("R10 single pulse", 32'(rsp_valid), 0);
    chk("R10 ready again", 32'(req_ready), 1);
    d_rd = rd_cnt - rd0; d_wr = wr_cnt - wr0;
  endtask

  task automatic t_reset();
    chk("R1 ready", 32'(req_ready), 1);
    chk("R1 rsp_valid", 32'(rsp_valid), 0);
    chk("R1 mem_req", 32'(mem_req), 0);
    chk("R1 fault_addr", fault_addr, 0);
    chk("R1 fault_code", 32'(fault_code), 0);
  endtask

  task automatic t_translate();
    poke(32'h100C, 32'h0000_2007);
    poke(32'h2014, 32'h0ABC_D007);
    walk(32'h00C0_5123, 0, 1);
    chk("R2 fault", 32'(got_fault), 0);
    chk("R2 paddr", got_paddr, 32'h0ABC_D123);
    chk("R5 pde accessed", mem[32'h100C >> 2], 32'h0000_2027);
    chk("R4 read no dirty", mem[32'h2014 >> 2], 32'h0ABC_D027);
    chk("R5 writes", d_wr, 2);
    chk("R2 reads", d_rd, 2);
    walk(32'h00C0_5FFF, 0, 0);
    chk("R2 paddr top", got_paddr, 32'h0ABC_DFFF);
    chk("R5 no write when set", d_wr, 0);
  endtask

  task automatic t_dirty();
    wp = 1;
    walk(32'h00C0_5008, 1, 0);
    chk("R4 fault", 32'(got_fault), 0);
    chk("R4 paddr", got_paddr, 32'h0ABC_D008);
    chk("R4 dirty set", mem[32'h2014 >> 2], 32'h0ABC_D067);
    chk("R4 one write", d_wr, 1);
    walk(32'h00C0_5008, 1, 1);
    chk("R4 already dirty no write", d_wr, 0);
  endtask

  task automatic t_pde_np();
    walk(32'h01C0_0456, 1, 1);
    chk("R6 fault", 32'(got_fault), 1);
    chk("R6 code", 32'(fault_code), 32'h6);
    chk("R6 one read", d_rd, 1);
    chk("R6 no write", d_wr, 0);
    chk("R9 fault addr", fault_addr, 32'h01C0_0456);
  endtask

  task automatic t_pte_np();
    walk(32'h00C0_9ABC, 0, 0);
    chk("R7 fault", 32'(got_fault), 1);
    chk("R7 code", 32'(fault_code), 32'h0);
    chk("R7 reads", d_rd, 2);
    chk("R9 fault addr", fault_addr, 32'h00C0_9ABC);
  endtask

  task automatic t_rights();
    poke(32'h1010, 32'h0000_3025);
    poke(32'h3000, 32'h0055_5027);
    poke(32'h3004, 32'h0066_6023);
    wp = 1;
    walk(32'h0100_0010, 0, 1);
    chk("R3 user read ok", 32'(got_fault), 0);
    chk("R3 paddr", got_paddr, 32'h0055_5010);
    walk(32'h0100_0010, 1, 1);
    chk("R3 user write W0", 32'(got_fault), 1);
    chk("R8 code", 32'(fault_code), 32'h7);
    chk("R8 no write", d_wr, 0);
    chk("R8 pte kept", mem[32'h3000 >> 2], 32'h0055_5027);
    wp = 0;
    walk(32'h0100_0010, 1, 1);
    chk("R3 user write wp0", 32'(fault_code), 32'h7);
    wp = 1;
    walk(32'h0100_0010, 1, 0);
    chk("R3 sup write wp1", 32'(got_fault), 1);
    chk("R8 sup code", 32'(fault_code), 32'h3);
    wp = 0;
    walk(32'h0100_0010, 1, 0);
    chk("R3 sup write wp0", 32'(got_fault), 0);
    chk("R4 dirty wp0", mem[32'h3000 >> 2], 32'h0055_5067);
    wp = 1;
    walk(32'h0100_1020, 0, 1);
    chk("R3 user no U", 32'(got_fault), 1);
    chk("R8 user code", 32'(fault_code), 32'h5);
  endtask

  task automatic t_hold();
    walk(32'h0100_1020, 0, 0);
    chk("R3 sup read no W", 32'(got_fault), 0);
    chk("R3 paddr", got_paddr, 32'h0066_6020);
    chk("R9 addr held", fault_addr, 32'h0100_1020);
    chk("R9 code held", 32'(fault_code), 32'h5);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_translate();
    t_dirty();
    t_pde_np();
    t_pte_np();
    t_rights();
    t_hold();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule